// File: doc/BRIEF.md
# Character LCD Write Bus Controller

This block lets a small CPU drive a parallel character LCD module that uses the common 8-bit instruction/data bus with a register-select line and an enable strobe. The CPU writes a byte to one of two addresses. Address 0 carries an instruction for the panel and address 1 carries a character. The block latches the byte and then runs a timed bus cycle. It places register-select and the data bus, waits a setup interval, raises enable for a programmable width and keeps the bus steady until the programmed cycle time has elapsed. After the cycle it waits a settling delay before it takes the next byte. Clear-display and return-home instructions get a long delay. Every other transfer gets a short delay.

The panel's read/write line is expected to be tied low on the board, so the block only writes and never samples the panel. Software finds out whether a new byte may be written by reading either address, where bit 7 is the ready flag. The block is built around a five-state sequencer: IDLE, SETUP, STROBE, HOLD and WAIT. These are its transitions:

- IDLE→SETUP when a write is accepted.
- SETUP→STROBE when the setup count is reached.
- STROBE→HOLD when the enable width is reached.
- HOLD→WAIT when the cycle time is reached.
- WAIT→IDLE when the delay timer expires.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: While reset is held and directly after it, the ready flag is 1, enable is 0, register-select is 0 and the data bus is 0x00.
- R2: A write to address 0 presents the byte with register-select 0, and a write to address 1 presents it with register-select 1. The data bus carries the written byte.
- R3: Enable first reads high at the SETUP_CYC-th clock edge after the edge that accepted the write.
- R4: Each accepted write produces exactly one enable pulse, and that pulse is EN_HIGH_CYC cycles wide.
- R5: Register-select and the data bus do not change from the accepting edge until the ready flag returns.
- R6: A read returns 0x80 when the block is ready and 0x00 when it is busy, for both address 0 and address 1. Bits 6..0 always read 0.
- R7: The ready flag falls on the accepting edge. For data writes and ordinary instructions it returns CYCLE_CYC + SHORT_WAIT cycles after that edge.
- R8: An address-0 write of 0x01 (clear), 0x02 or 0x03 (home) makes the ready flag return CYCLE_CYC + LONG_WAIT cycles after acceptance. The same bytes written to address 1 use the short delay.
- R9: A write presented while the ready flag is 0 is ignored. This includes a write in the last busy cycle. The bus contents, the number of enable pulses and the ready timing of the running transfer stay unchanged.
- R10: A write presented in the first cycle that the ready flag reads 1 is accepted, and the ready flag reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe, one cycle per byte |
| cpu_addr | input | 1 | 0 = instruction register, 1 = character register |
| cpu_wdata | input | 8 | Byte to send |
| cpu_rdata | output | 8 | Read data, bit 7 = ready |
| lcd_rs | output | 1 | Panel register-select |
| lcd_en | output | 1 | Panel enable strobe |
| lcd_db | output | 8 | Panel data bus |

## Verification
The delay timer expiring (WAIT→IDLE) and a new CPU write being accepted are the two functions that can collide in one cycle. The bench sets up the collision by presenting a write exactly in the last busy cycle, then presenting another write in the very first ready cycle. It expects the first write to leave the bus and the ready timing unchanged. It expects the second write to start a fresh transfer whose ready flag reads 0 immediately, followed by a normally timed enable pulse.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_WAIT   = 3'd4
    } lcd_state_e;

    // Instructions that need the long settling delay: clear (0x01), home (0x02/0x03)
    function automatic logic is_slow_cmd(input logic [7:0] b);
        return (b[7:2] == 6'd0) && (b[1:0] != 2'd0);
    endfunction

endpackage

// File: rtl/lcd_reg_decode.sv
module lcd_reg_decode
    import lcd_bus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic          cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          ready,
    output logic          accept,
    output logic          lat_rs,
    output logic [DW-1:0] lat_db,
    output logic          lat_slow,
    output logic [DW-1:0] rdata
);

    assign accept = cpu_wr && ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_rs   <= 1'b0;
            lat_db   <= '0;
            lat_slow <= 1'b0;
        end else if (accept) begin
            lat_rs   <= cpu_addr;
            lat_db   <= cpu_wdata;
            lat_slow <= !cpu_addr && is_slow_cmd(cpu_wdata[7:0]);
        end
    end

    // Both addresses return the same status byte
    always_comb begin
        rdata         = '0;
        rdata[DW-1]   = ready;
    end

endmodule

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
    parameter int SHORT_WAIT = 3700,
    parameter int LONG_WAIT  = 152000,
    localparam int TW = $clog2(LONG_WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic slow,
    input  logic run,
    output logic expired
);

    localparam logic [TW-1:0] SHORT_LOAD = TW'(SHORT_WAIT - 1);
    localparam logic [TW-1:0] LONG_LOAD  = TW'(LONG_WAIT - 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= slow ? LONG_LOAD : SHORT_LOAD;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_bus_pkg::*;
#(
    parameter int SETUP_CYC   = 5,
    parameter int EN_HIGH_CYC = 25,
    parameter int CYCLE_CYC   = 60,
    localparam int CW = $clog2(CYCLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic timer_expired,
    output logic ready,
    output logic en,
    output logic timer_load,
    output logic timer_run
);

    localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] STROBE_LAST = CW'(SETUP_CYC + EN_HIGH_CYC - 1);
    localparam logic [CW-1:0] CYCLE_LAST  = CW'(CYCLE_CYC - 1);

    lcd_state_e    state, state_nx;
    logic [CW-1:0] elapsed;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Cycles since acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (accept) begin
            elapsed <= '0;
        end else if (state != ST_IDLE && state != ST_WAIT) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept)                   state_nx = ST_SETUP;
            ST_SETUP:  if (elapsed == SETUP_LAST)    state_nx = ST_STROBE;
            ST_STROBE: if (elapsed == STROBE_LAST)   state_nx = ST_HOLD;
            ST_HOLD:   if (elapsed == CYCLE_LAST)    state_nx = ST_WAIT;
            ST_WAIT:   if (timer_expired)            state_nx = ST_IDLE;
            default:                                 state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready      = 1'b0;
        en         = 1'b0;
        timer_load = 1'b0;
        timer_run  = 1'b0;
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_SETUP:  ;
            ST_STROBE: en = 1'b1;
            ST_HOLD:   timer_load = (elapsed == CYCLE_LAST);
            ST_WAIT:   timer_run = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl #(
    parameter int SETUP_CYC   = 5,
    parameter int EN_HIGH_CYC = 25,
    parameter int CYCLE_CYC   = 60,
    parameter int SHORT_WAIT  = 3700,
    parameter int LONG_WAIT   = 152000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_wr,
    input  logic       cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       lcd_rs,
    output logic       lcd_en,
    output logic [7:0] lcd_db
);

    logic ready, accept, slow, t_load, t_run, t_exp;

    lcd_reg_decode #(.DW(8)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .ready    (ready),
        .accept   (accept),
        .lat_rs   (lcd_rs),
        .lat_db   (lcd_db),
        .lat_slow (slow),
        .rdata    (cpu_rdata)
    );

    lcd_phase_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .EN_HIGH_CYC(EN_HIGH_CYC),
        .CYCLE_CYC  (CYCLE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .timer_expired(t_exp),
        .ready        (ready),
        .en           (lcd_en),
        .timer_load   (t_load),
        .timer_run    (t_run)
    );

    lcd_delay_timer #(
        .SHORT_WAIT(SHORT_WAIT),
        .LONG_WAIT (LONG_WAIT)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (t_load),
        .slow   (slow),
        .run    (t_run),
        .expired(t_exp)
    );

endmodule

// File: rtl/lcd_bus_ctrl_chk.sv
module lcd_bus_ctrl_chk #(
    parameter int SETUP_CYC   = 5,
    parameter int EN_HIGH_CYC = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_wr,
    input logic [7:0] cpu_rdata,
    input logic       lcd_rs,
    input logic       lcd_en,
    input logic [7:0] lcd_db
);

    logic        rdy;
    logic [15:0] en_len;
    logic [15:0] since_acc;

    assign rdy = cpu_rdata[7];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_len    <= '0;
            since_acc <= '0;
        end else begin
            en_len <= lcd_en ? en_len + 1'b1 : '0;
            if (cpu_wr && rdy)
                since_acc <= '0;
            else if (since_acc != 16'hFFFF)
                since_acc <= since_acc + 1'b1;
        end
    end

    a_r3_setup_time: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> since_acc == 16'(SETUP_CYC));

    a_r4_en_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> en_len == 16'(EN_HIGH_CYC));

    a_r4_no_en_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> !lcd_en);

    a_r5_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && $past(!rdy)) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[6:0] == 7'd0);

    a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && rdy) |=> !rdy);

    a_r9_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(cpu_wr));

endmodule

bind lcd_bus_ctrl lcd_bus_ctrl_chk #(
    .SETUP_CYC  (SETUP_CYC),
    .EN_HIGH_CYC(EN_HIGH_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_rdata(cpu_rdata),
    .lcd_rs   (lcd_rs),
    .lcd_en   (lcd_en),
    .lcd_db   (lcd_db)
);

// File: tb/lcd_bus_ctrl_bench.sv
`timescale 1ns/1ps
module lcd_bus_ctrl_bench;

    localparam int SU = 2;
    localparam int EH = 3;
    localparam int CY = 8;
    localparam int SW = 5;
    localparam int LW = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       lcd_rs, lcd_en;
    logic [7:0] lcd_db;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lcd_bus_ctrl #(
        .SETUP_CYC(SU), .EN_HIGH_CYC(EH), .CYCLE_CYC(CY),
        .SHORT_WAIT(SW), .LONG_WAIT(LW)
    ) u_lcd_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .lcd_rs(lcd_rs), .lcd_en(lcd_en), .lcd_db(lcd_db)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One transfer; t=0 is the negedge right after the accepting edge.
    task automatic run_xfer(input bit addr, input logic [7:0] data, input int wait_c,
                            input bit back2back, input int inj_t,
                            input bit inj_addr, input logic [7:0] inj_data,
                            input string tag);
        int rise_t = -1, en_cnt = 0, rdy_t = -1, bus_bad = 0;
        bit prev_en = 0;
        if (!back2back) @(negedge clk);
        cpu_addr = addr; cpu_wdata = data; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        check(cpu_rdata == 8'h00, {tag, " R6/R7 busy read"}, cpu_rdata, 0);
        for (int t = 0; t < 200; t++) begin
            if (lcd_en && !prev_en && rise_t < 0) rise_t = t;
            if (lcd_en) en_cnt++;
            prev_en = lcd_en;
            if (cpu_rdata[7]) begin rdy_t = t; break; end
            if (lcd_rs !== addr || lcd_db !== data) bus_bad++;
            if (t == inj_t) begin
                cpu_addr = inj_addr; cpu_wdata = inj_data; cpu_wr = 1'b1;
            end else begin
                cpu_wr = 1'b0;
            end
            @(negedge clk);
        end
        cpu_wr = 1'b0;
        check(bus_bad == 0, {tag, " R2/R5/R9 bus held"}, bus_bad, 0);
        check(rise_t == SU, {tag, " R3 enable rise"}, rise_t, SU);
        check(en_cnt == EH, {tag, " R4/R9 enable width"}, en_cnt, EH);
        check(rdy_t == CY + wait_c, {tag, " R7/R8/R9 ready return"}, rdy_t, CY + wait_c);
        check(cpu_rdata == 8'h80, {tag, " R6 ready read"}, cpu_rdata, 8'h80);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cpu_rdata == 8'h80 && !lcd_en && !lcd_rs && lcd_db == 8'h00,
              "R1 in reset", {cpu_rdata, lcd_db}, 16'h8000);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_rdata == 8'h80 && !lcd_en && !lcd_rs && lcd_db == 8'h00,
              "R1 after reset", {cpu_rdata, lcd_db}, 16'h8000);
    endtask

    task automatic t_read_both();
        cpu_addr = 1'b0; #1;
        check(cpu_rdata == 8'h80, "R6 read addr0", cpu_rdata, 8'h80);
        cpu_addr = 1'b1; #1;
        check(cpu_rdata == 8'h80, "R6 read addr1", cpu_rdata, 8'h80);
    endtask

    task automatic t_data();     run_xfer(1'b1, 8'h41, SW, 0, -1, 0, 0, "R2 data"); endtask
    task automatic t_cmd_short(); run_xfer(1'b0, 8'h38, SW, 0, -1, 0, 0, "R7 cmd");  endtask
    task automatic t_clear();    run_xfer(1'b0, 8'h01, LW, 0, -1, 0, 0, "R8 clear"); endtask
    task automatic t_home2();    run_xfer(1'b0, 8'h02, LW, 0, -1, 0, 0, "R8 home2"); endtask
    task automatic t_home3();    run_xfer(1'b0, 8'h03, LW, 0, -1, 0, 0, "R8 home3"); endtask
    task automatic t_slow_as_data(); run_xfer(1'b1, 8'h02, SW, 0, -1, 0, 0, "R8 data02"); endtask
    task automatic t_ignore_mid(); run_xfer(1'b0, 8'h0C, SW, 0, SU + 1, 1'b1, 8'h55, "R9 mid"); endtask

    task automatic t_boundary();
        // write in last busy cycle ignored, then one in first ready cycle accepted
        run_xfer(1'b1, 8'h7A, SW, 0, CY + SW - 1, 1'b1, 8'hA5, "R9 last busy");
        run_xfer(1'b1, 8'h42, SW, 1, -1, 0, 0, "R10 first ready");
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        t_reset();
        t_read_both();
        t_data();
        t_cmd_short();
        t_clear();
        t_home2();
        t_home3();
        t_slow_as_data();
        t_ignore_mid();
        t_boundary();
        t_read_both();
        summary();
    end

endmodule